// File: doc/BRIEF.md
# Multiframe Clock Phase Generator

This block produces the frame-boundary strobe and the multiframe-boundary strobe for a converter serial link. It runs in the device clock domain and advances by one octet on every clock. An octet counter wraps at the configured frame length. A frame counter advances on each octet wrap and wraps at the configured multiframe length. A multiframe boundary is the first octet of frame zero, and that boundary is the timing reference that gives the link a known, repeatable latency.

The phase of both counters can be reset by an external reference, and the subclass setting selects which one. In subclass 1 a rising edge on the system reference input aligns the counters. In subclass 2 a falling edge on the active-low synchronisation request aligns them. In subclass 0 nothing aligns them and the counters run freely. A flag reports that an accepted reference edge has set the phase. An option freezes the phase after the first alignment, so that later reference edges are ignored.

A small state machine tracks alignment. Its states are FREE (subclass 0 or reserved, no reference used), SEEK (reference selected, waiting for its first edge) and LOCKED (phase set by an accepted edge). Reset enters SEEK. The transitions are: SEEK→LOCKED on an accepted edge; FREE→LOCKED on an accepted edge; SEEK→FREE and LOCKED→FREE when the subclass becomes 0 or 3; FREE→SEEK when subclass 1 or 2 is selected without an edge; LOCKED→LOCKED on an accepted re-alignment.

Top module: `mfclk_phase_gen`

## Requirements
- R1: While rst_n is low, and in the first cycle after it is released, both counters hold zero. In that state frame_start=1, lmfc_start=1 and phase_locked=0.
- R2: octets_m1 holds the frame length minus one and frames_m1 holds the multiframe length minus one. frame_start is high in the first octet of every frame, which repeats every octets_m1+1 cycles. lmfc_start is high only in the first octet of frame 0, which repeats every (octets_m1+1)*(frames_m1+1) cycles.
- R3: The frame length ranges from 1 to 16 octets and the multiframe length from 1 to 32 frames. With both fields at 0, both strobes are high on every cycle.
- R4: With subclass_sel=1, a sysref that is high in a cycle after being low in the previous cycle is an alignment edge. In the next cycle frame_start=1, lmfc_start=1 and phase_locked=1, and counting restarts from octet 0 of frame 0.
- R5: With subclass_sel=2, a sync_n that is low in a cycle after being high in the previous cycle is the alignment edge, with the same effect as R4. In this subclass sysref edges and rising edges of sync_n have no effect.
- R6: With subclass_sel=0 or the reserved code 3, no edge aligns the counters, the strobes keep their free-running cadence, and phase_locked is low from the next cycle onward.
- R7: Once set, phase_locked stays high while subclass_sel is 1 or 2, until a reset occurs or R6 applies.
- R8: While phase_locked=1 and hold_after_lock=1, reference edges are ignored and the strobe cadence continues unchanged.
- R9: With hold_after_lock=0, every later accepted edge realigns the counters as in R4.
- R10: An edge that arrives when the counters would wrap to octet 0 of frame 0 anyway causes no visible phase change.
- R11: A reference held at its active level aligns only once. Only the transition counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock, one octet per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| subclass_sel | input | 2 | 0 free run, 1 system reference, 2 sync request, 3 reserved (as 0) |
| sysref | input | 1 | System reference input (phase source in subclass 1) |
| sync_n | input | 1 | Active-low synchronisation request (phase source in subclass 2) |
| hold_after_lock | input | 1 | Ignore reference edges while aligned |
| octets_m1 | input | OCT_W | Octets per frame minus one |
| frames_m1 | input | FRM_W | Frames per multiframe minus one |
| frame_start | output | 1 | High in the first octet of each frame |
| lmfc_start | output | 1 | High in the first octet of each multiframe |
| phase_locked | output | 1 | Phase has been set by an accepted reference edge |

## Verification
A reference edge that is present at clock edge k shows on the strobes and on phase_locked from k until k+1. There is no extra pipeline stage, because the strobes are decoded from the counter registers. Subclass changes move phase_locked one cycle after they are sampled. The bench drives inputs on falling edges and updates its own model at each rising edge. It pushes that cycle's expected strobes and flag into a queue, and the monitor pops the entry and compares it on the next falling edge. Every cycle is therefore compared in the cycle in which the outputs are due.

// File: rtl/mfclk_pkg.sv
package mfclk_pkg;

    typedef enum logic [1:0] {
        ST_FREE   = 2'd0,
        ST_SEEK   = 2'd1,
        ST_LOCKED = 2'd2
    } align_state_t;

    localparam logic [1:0] SUBCLASS_FREE   = 2'd0;
    localparam logic [1:0] SUBCLASS_SYSREF = 2'd1;
    localparam logic [1:0] SUBCLASS_SYNC   = 2'd2;

    function automatic logic subclass_uses_ref(input logic [1:0] sel);
        return (sel == SUBCLASS_SYSREF) || (sel == SUBCLASS_SYNC);
    endfunction

endpackage

// File: rtl/mfclk_edge_det.sv
module mfclk_edge_det #(
    parameter bit RISING = 1'b1
) (
    input  logic clk,
    input  logic din,
    output logic pulse
);
    logic din_q;

    // Loads the input even while in reset, so no edge is seen right after reset.
    always_ff @(posedge clk) begin
        din_q <= din;
    end

    generate
        if (RISING) begin : g_rise
            assign pulse = din & ~din_q;
        end else begin : g_fall
            assign pulse = ~din & din_q;
        end
    endgenerate
endmodule

// File: rtl/mfclk_phase_ctr.sv
module mfclk_phase_ctr #(
    parameter int OCT_W = 4,
    parameter int FRM_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_zero,
    input  logic [OCT_W-1:0] octets_m1,
    input  logic [FRM_W-1:0] frames_m1,
    output logic             frame_start,
    output logic             lmfc_start
);
    logic [OCT_W-1:0] oct_cnt;
    logic [FRM_W-1:0] frm_cnt;
    logic             oct_wrap;
    logic             frm_wrap;

    // Greater-or-equal so that a shortened setting wraps at once.
    assign oct_wrap = (oct_cnt >= octets_m1);
    assign frm_wrap = (frm_cnt >= frames_m1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oct_cnt <= '0;
            frm_cnt <= '0;
        end else if (load_zero) begin
            oct_cnt <= '0;
            frm_cnt <= '0;
        end else if (oct_wrap) begin
            oct_cnt <= '0;
            frm_cnt <= frm_wrap ? '0 : frm_cnt + 1'b1;
        end else begin
            oct_cnt <= oct_cnt + 1'b1;
        end
    end

    assign frame_start = (oct_cnt == '0);
    assign lmfc_start  = (oct_cnt == '0) && (frm_cnt == '0);
endmodule

// File: rtl/mfclk_align_fsm.sv
module mfclk_align_fsm
    import mfclk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] subclass_sel,
    input  logic       sysref_rise,
    input  logic       sync_fall,
    input  logic       hold_en,
    output logic       align_now,
    output logic       locked
);
    align_state_t state, state_nx;
    logic         ref_evt;
    logic         sub_active;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_SEEK;
        else        state <= state_nx;
    end

    always_comb begin
        sub_active = subclass_uses_ref(subclass_sel);
        ref_evt    = ((subclass_sel == SUBCLASS_SYSREF) && sysref_rise) ||
                     ((subclass_sel == SUBCLASS_SYNC)   && sync_fall);
        align_now  = ref_evt && !((state == ST_LOCKED) && hold_en);
        locked     = (state == ST_LOCKED);
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FREE: begin
                if (align_now)       state_nx = ST_LOCKED;
                else if (sub_active) state_nx = ST_SEEK;
            end
            ST_SEEK: begin
                if (align_now)        state_nx = ST_LOCKED;
                else if (!sub_active) state_nx = ST_FREE;
            end
            ST_LOCKED: begin
                if (!sub_active) state_nx = ST_FREE;
            end
            default: state_nx = ST_SEEK;
        endcase
    end
endmodule

// File: rtl/mfclk_phase_gen.sv
module mfclk_phase_gen #(
    parameter int OCT_W = 4,
    parameter int FRM_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       subclass_sel,
    input  logic             sysref,
    input  logic             sync_n,
    input  logic             hold_after_lock,
    input  logic [OCT_W-1:0] octets_m1,
    input  logic [FRM_W-1:0] frames_m1,
    output logic             frame_start,
    output logic             lmfc_start,
    output logic             phase_locked
);
    logic sysref_rise;
    logic sync_fall;
    logic align_now;

    mfclk_edge_det #(.RISING(1'b1)) u_sysref_edge (
        .clk   (clk),
        .din   (sysref),
        .pulse (sysref_rise)
    );

    mfclk_edge_det #(.RISING(1'b0)) u_sync_edge (
        .clk   (clk),
        .din   (sync_n),
        .pulse (sync_fall)
    );

    mfclk_align_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .subclass_sel (subclass_sel),
        .sysref_rise  (sysref_rise),
        .sync_fall    (sync_fall),
        .hold_en      (hold_after_lock),
        .align_now    (align_now),
        .locked       (phase_locked)
    );

    mfclk_phase_ctr #(.OCT_W(OCT_W), .FRM_W(FRM_W)) u_ctr (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_zero   (align_now),
        .octets_m1   (octets_m1),
        .frames_m1   (frames_m1),
        .frame_start (frame_start),
        .lmfc_start  (lmfc_start)
    );
endmodule

// File: rtl/mfclk_phase_gen_chk.sv
module mfclk_phase_gen_chk #(
    parameter int OCT_W = 4,
    parameter int FRM_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       subclass_sel,
    input logic             sysref,
    input logic             sync_n,
    input logic             hold_after_lock,
    input logic [OCT_W-1:0] octets_m1,
    input logic [FRM_W-1:0] frames_m1,
    input logic             frame_start,
    input logic             lmfc_start,
    input logic             phase_locked
);
    // R2: a multiframe boundary is always a frame boundary
    assert_lmfc_on_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lmfc_start |-> frame_start);

    // R3: shortest settings give a boundary on every cycle
    assert_min_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (octets_m1 == '0 && frames_m1 == '0) |=> lmfc_start);

    // R4: accepted system reference edge aligns in the next cycle
    assert_sysref_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (subclass_sel == 2'd1 && sysref && !$past(sysref) &&
         !(phase_locked && hold_after_lock)) |=> (lmfc_start && phase_locked));

    // R5: accepted sync request edge aligns in the next cycle
    assert_sync_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (subclass_sel == 2'd2 && !sync_n && $past(sync_n) &&
         !(phase_locked && hold_after_lock)) |=> (lmfc_start && phase_locked));

    // R6: no reference in free-running subclasses
    assert_free_unlocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (subclass_sel == 2'd0 || subclass_sel == 2'd3) |=> !phase_locked);

    // R7: lock persists while a reference subclass is selected
    assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_locked && (subclass_sel == 2'd1 || subclass_sel == 2'd2)) |=> phase_locked);
endmodule

bind mfclk_phase_gen mfclk_phase_gen_chk #(.OCT_W(OCT_W), .FRM_W(FRM_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .subclass_sel    (subclass_sel),
    .sysref          (sysref),
    .sync_n          (sync_n),
    .hold_after_lock (hold_after_lock),
    .octets_m1       (octets_m1),
    .frames_m1       (frames_m1),
    .frame_start     (frame_start),
    .lmfc_start      (lmfc_start),
    .phase_locked    (phase_locked)
);

// File: tb/mfclk_phase_gen_test.sv
module mfclk_phase_gen_test;
    localparam int OCT_W = 4;
    localparam int FRM_W = 5;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [1:0]       subclass_sel;
    logic             sysref;
    logic             sync_n;
    logic             hold_after_lock;
    logic [OCT_W-1:0] octets_m1;
    logic [FRM_W-1:0] frames_m1;
    logic             frame_start;
    logic             lmfc_start;
    logic             phase_locked;

    always #5 clk = ~clk;

    mfclk_phase_gen #(.OCT_W(OCT_W), .FRM_W(FRM_W)) uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .subclass_sel    (subclass_sel),
        .sysref          (sysref),
        .sync_n          (sync_n),
        .hold_after_lock (hold_after_lock),
        .octets_m1       (octets_m1),
        .frames_m1       (frames_m1),
        .frame_start     (frame_start),
        .lmfc_start      (lmfc_start),
        .phase_locked    (phase_locked)
    );

    typedef struct {
        logic  fs;
        logic  ls;
        logic  pl;
        string tag;
    } exp_t;

    exp_t sbq[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    int   m_oct  = 0;
    int   m_frm  = 0;
    bit   m_lock = 1'b0;
    logic m_psys = 1'b0;
    logic m_psync = 1'b1;

    // Driver: updates the model at each rising edge and queues the expected outputs.
    task automatic tick(input string tag);
        exp_t e;
        bit   rise;
        bit   fall;
        bit   evt;
        bit   act;
        @(posedge clk);
        if (!rst_n) begin
            m_oct = 0; m_frm = 0; m_lock = 1'b0;
        end else begin
            rise = (sysref === 1'b1) && (m_psys === 1'b0);
            fall = (sync_n === 1'b0) && (m_psync === 1'b1);
            evt  = (subclass_sel == 2'd1 && rise) || (subclass_sel == 2'd2 && fall);
            act  = (subclass_sel == 2'd1) || (subclass_sel == 2'd2);
            if (evt && !(m_lock && hold_after_lock)) begin
                m_oct = 0; m_frm = 0; m_lock = 1'b1;
            end else begin
                if (m_oct >= int'(octets_m1)) begin
                    m_oct = 0;
                    m_frm = (m_frm >= int'(frames_m1)) ? 0 : m_frm + 1;
                end else begin
                    m_oct = m_oct + 1;
                end
                if (!act) m_lock = 1'b0;
            end
        end
        m_psys  = sysref;
        m_psync = sync_n;
        e.fs  = (m_oct == 0);
        e.ls  = (m_oct == 0) && (m_frm == 0);
        e.pl  = m_lock;
        e.tag = tag;
        sbq.push_back(e);
        @(negedge clk);
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) tick(tag);
    endtask

    task automatic ref_pulse(input string tag);
        sysref = 1'b1;
        tick(tag);
        sysref = 1'b0;
    endtask

    // Monitor: compares the queued expectation at the falling edge.
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (sbq.size() > 0) begin
                e = sbq.pop_front();
                n_cmp++;
                if (frame_start !== e.fs || lmfc_start !== e.ls || phase_locked !== e.pl) begin
                    n_bad++;
                    $display("FAIL %s: frame/lmfc/locked actual %b%b%b expected %b%b%b at %0t",
                             e.tag, frame_start, lmfc_start, phase_locked,
                             e.fs, e.ls, e.pl, $time);
                end
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual run still active, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; subclass_sel = 2'd0; sysref = 1'b0; sync_n = 1'b1;
        hold_after_lock = 1'b0; octets_m1 = 4'd3; frames_m1 = 5'd1;
        run(3, "R1");
        rst_n = 1'b1;
        tick("R1");
        run(20, "R2");
        // R6: subclass 0 and reserved code ignore the reference
        ref_pulse("R6");
        run(10, "R6");
        subclass_sel = 2'd3;
        run(2, "R6");
        ref_pulse("R6");
        run(10, "R6");
        // R4 and R11: alignment mid-frame, level held high
        subclass_sel = 2'd1;
        run(5, "R4");
        sysref = 1'b1;
        tick("R4");
        run(12, "R11");
        sysref = 1'b0;
        run(5, "R4");
        // R9: realignment without hold
        run(2, "R9");
        ref_pulse("R9");
        run(12, "R9");
        // R10: edge on an existing boundary
        while (!(m_oct == 3 && m_frm == 1)) tick("R10");
        ref_pulse("R10");
        run(16, "R10");
        // R8: hold ignores edges once aligned
        hold_after_lock = 1'b1;
        run(3, "R8");
        ref_pulse("R8");
        run(12, "R8");
        hold_after_lock = 1'b0;
        // R7 and R5: switch to sync request subclass
        subclass_sel = 2'd2;
        run(5, "R7");
        run(1, "R5");
        ref_pulse("R5");
        run(6, "R5");
        sync_n = 1'b0;
        tick("R5");
        run(6, "R5");
        sync_n = 1'b1;
        run(10, "R5");
        // R6: lock clears when the reference is deselected
        subclass_sel = 2'd0;
        run(6, "R6");
        // R3: extreme lengths
        octets_m1 = 4'd0; frames_m1 = 5'd0;
        run(10, "R3");
        octets_m1 = 4'd15; frames_m1 = 5'd31;
        subclass_sel = 2'd1;
        run(3, "R3");
        ref_pulse("R3");
        run(1100, "R3");
        octets_m1 = 4'd0;
        run(70, "R3");
        // R1: reset in mid-run
        octets_m1 = 4'd2; frames_m1 = 5'd2;
        rst_n = 1'b0;
        run(2, "R1");
        rst_n = 1'b1;
        tick("R1");
        run(8, "R2");
        #1;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule